// File: doc/BRIEF.md
# Four-Source Interrupt Detector and Identifier

This block watches four active-low interrupt request lines: a transmit-register-empty line, an air-data-ready line, a drift-angle-clear line and a receiver/transmitter data-error line. Each line is brought into the clock domain through a synchroniser. A high-to-low transition on a line marks that source as pending. When no interrupt sequence is in progress, the highest-priority pending source becomes the serviced source, and the interrupt request output to the processor is raised.

The processor identifies the serviced source by asserting the identification read strobe. The strobe is already qualified by the address decode, the bus phase and the read control. During that read, the data output carries a single bit for the serviced source at a fixed position, together with the antenna side status. The processor ends the sequence with the end-of-service input. Any request that arrived during the sequence has been held, and it is presented after one idle cycle.

Top module: `irq_source_ident`

## Requirements
- R1: A high-to-low transition on any `req_n` line causes `irq` to go high on the fourth rising clock edge after the first edge that samples the line low, provided no sequence is in progress.
- R2: Only a falling edge counts. A line that is held low, or that returns high, raises no further request.
- R3: During an identification read, the serviced source appears on a single data bit: bit 7 for transmit-register empty (`req_n[3]`), bit 6 for air-data ready (`req_n[2]`), bit 4 for drift-angle clear (`req_n[1]`) and bit 3 for data error (`req_n[0]`). No other source bit is set.
- R4: During an identification read, bit 1 equals `ant_right` (1 means right, 0 means left), and bits 0, 2 and 5 are zero. When `id_rd` is low, `rd_data` is 8'h00.
- R5: While a sequence is in progress, `irq` stays high and the serviced source does not change. Requests that arrive in the meantime are stored.
- R6: With `svc_done` high on a clock edge during a sequence, `irq` is low after that edge. If a stored request exists, `irq` goes high again on the following edge.
- R7: When several sources are pending, they are serviced in the order bit 7, bit 6, bit 4, bit 3.
- R8: A new falling edge on the source currently being serviced is stored, and that source is serviced again after the current sequence ends.
- R9: After reset, with all lines high, `irq` is low and nothing is pending. A `svc_done` pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 4 | Active-low request lines: [0] data error, [1] drift-angle clear, [2] air-data ready, [3] transmit-register empty |
| ant_right | input | 1 | Antenna side status, 1 = right |
| id_rd | input | 1 | Qualified identification read strobe |
| svc_done | input | 1 | End of the current interrupt sequence |
| irq | output | 1 | Interrupt request to the processor |
| rd_data | output | 8 | Identification byte, zero when not read |

## Verification
The main function is exercised with request patterns that contain one, two, three and four simultaneous falling edges, under both antenna states. These patterns separate the fixed bit mapping from the priority order and from the storing of further requests. Directed patterns add a line held low for a long time, which separates edge detection from level detection. They also add a repeated edge on the source being serviced, a higher-priority arrival in the middle of a sequence, which must not pre-empt it, and an end-of-service pulse while idle.

// File: rtl/irq_id_pkg.sv
package irq_id_pkg;
    localparam int NSRC    = 4;
    localparam int DATA_W  = 8;
    localparam int ANT_POS = 1;

    typedef logic [NSRC-1:0] src_vec_t;

    typedef struct packed {
        src_vec_t pend;
        src_vec_t act;
    } arb_state_t;

    // fixed data-bit position of each source index
    function automatic int src_pos(input int idx);
        case (idx)
            0:       return 3;
            1:       return 4;
            2:       return 6;
            default: return 7;
        endcase
    endfunction
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
    parameter int NSRC   = 4,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req_n,
    output logic [NSRC-1:0] fall
);
    for (genvar g = 0; g < NSRC; g++) begin : g_line
        logic [STAGES:0] sh_d, sh_q;

        always_comb begin
            sh_d = {sh_q[STAGES-1:0], req_n[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '1;
            else        sh_q <= sh_d;
        end

        // synchronised level low now, high one cycle earlier
        assign fall[g] = ~sh_q[STAGES-1] & sh_q[STAGES];
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_id_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  src_vec_t fall,
    input  logic     svc_done,
    output src_vec_t act_q,
    output logic     irq
);
    arb_state_t s_d, s_q;
    src_vec_t   pick;

    always_comb begin
        pick = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (s_q.pend[i]) pick = src_vec_t'(1) << i;
        end
        s_d = s_q;
        if (|s_q.act) begin
            if (svc_done) s_d.act = '0;
        end else begin
            s_d.act  = pick;
            s_d.pend = s_q.pend & ~pick;
        end
        s_d.pend = s_d.pend | fall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_q = s_q.act;
    assign irq   = |s_q.act;
endmodule

// File: rtl/irq_id_readout.sv
module irq_id_readout
    import irq_id_pkg::*;
(
    input  src_vec_t            act,
    input  logic                ant_right,
    input  logic                id_rd,
    output logic [DATA_W-1:0]   rd_data
);
    always_comb begin
        rd_data = '0;
        if (id_rd) begin
            for (int i = 0; i < NSRC; i++) rd_data[src_pos(i)] = act[i];
            rd_data[ANT_POS] = ant_right;
        end
    end
endmodule

// File: rtl/irq_source_ident.sv
module irq_source_ident
    import irq_id_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   req_n,
    input  logic              ant_right,
    input  logic              id_rd,
    input  logic              svc_done,
    output logic              irq,
    output logic [DATA_W-1:0] rd_data
);
    src_vec_t fall;
    src_vec_t act_q;

    irq_sync_edge #(.NSRC(NSRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .fall(fall)
    );

    irq_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .fall(fall), .svc_done(svc_done),
        .act_q(act_q), .irq(irq)
    );

    irq_id_readout u_rd (
        .act(act_q), .ant_right(ant_right), .id_rd(id_rd), .rd_data(rd_data)
    );
endmodule

// File: rtl/irq_source_ident_chk.sv
module irq_source_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       id_rd,
    input logic       svc_done,
    input logic       irq,
    input logic [7:0] rd_data,
    input logic [3:0] act
);
    a_r6_drop_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq && svc_done |=> !irq);

    a_r5_hold_service: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !svc_done |=> irq && $stable(act));

    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !id_rd |-> rd_data == 8'h00);

    a_r4_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[0] == 1'b0 && rd_data[2] == 1'b0 && rd_data[5] == 1'b0);

    a_r3_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_data[7:6], rd_data[4:3]}));

    a_r3_id_matches_irq: assert property (@(posedge clk) disable iff (!rst_n)
        id_rd && irq |-> $countones({rd_data[7:6], rd_data[4:3]}) == 1);
endmodule

bind irq_source_ident irq_source_ident_chk u_chk (
    .clk(clk), .rst_n(rst_n), .id_rd(id_rd), .svc_done(svc_done),
    .irq(irq), .rd_data(rd_data), .act(act_q)
);

// File: tb/test_irq_source_ident.sv
`timescale 1ns/1ps
module test_irq_source_ident;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_n = 4'hF;
    logic       ant_right = 1'b0;
    logic       id_rd = 1'b0;
    logic       svc_done = 1'b0;
    logic       irq;
    logic [7:0] rd_data;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    irq_source_ident i_irq_source_ident (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .ant_right(ant_right),
        .id_rd(id_rd), .svc_done(svc_done), .irq(irq), .rd_data(rd_data)
    );

    // {mask of sources to pulse, antenna}
    localparam logic [4:0] VEC [8] = '{
        5'b0001_0, 5'b0010_1, 5'b0100_0, 5'b1000_1,
        5'b1001_0, 5'b0110_1, 5'b1011_1, 5'b1111_0
    };

    function automatic int bpos(input int idx);
        int p [4] = '{3, 4, 6, 7};
        return p[idx];
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [3:0] mask);
        @(negedge clk) req_n = ~mask;
        repeat (2) @(negedge clk);
        req_n = 4'hF;
    endtask

    task automatic wait_irq();
        for (int k = 0; k < 20 && !irq; k++) @(negedge clk);
    endtask

    task automatic serve(input string req, input int idx, input logic more);
        id_rd = 1'b1;
        #1 check(req, rd_data, 8'(1 << bpos(idx)) | 8'(ant_right << 1));
        id_rd = 1'b0;
        svc_done = 1'b1;
        @(negedge clk) svc_done = 1'b0;
        check("R6 irq low after done", {7'd0, irq}, 8'd0);
        if (more) begin
            @(negedge clk);
            check("R6 held request re-raised", {7'd0, irq}, 8'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        check("R9 irq at reset", {7'd0, irq}, 8'd0);
        check("R4 data idle", rd_data, 8'h00);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 no spurious irq", {7'd0, irq}, 8'd0);
        ant_right = 1'b1; id_rd = 1'b1;
        #1 check("R4 antenna only when idle", rd_data, 8'h02);
        id_rd = 1'b0;

        // table: R3 R7 R4
        foreach (VEC[v]) begin
            logic [3:0] rem;
            rem = VEC[v][4:1];
            ant_right = VEC[v][0];
            pulse(rem);
            wait_irq();
            while (rem != 0) begin
                int top;
                top = 0;
                for (int i = 0; i < 4; i++) if (rem[i]) top = i;
                rem[top] = 1'b0;
                serve("R3 R7 id byte", top, rem != 0);
            end
            repeat (5) @(negedge clk);
            check("R2 no extra irq", {7'd0, irq}, 8'd0);
        end

        // R1 latency
        @(negedge clk) req_n = 4'b1110;
        repeat (3) @(negedge clk);
        check("R1 irq not before 4th edge", {7'd0, irq}, 8'd0);
        @(negedge clk);
        check("R1 irq at 4th edge", {7'd0, irq}, 8'd1);
        // R2 line held low: single service only
        repeat (10) @(negedge clk);
        serve("R2 held line id", 0, 1'b0);
        repeat (10) @(negedge clk);
        check("R2 held low no re-request", {7'd0, irq}, 8'd0);
        req_n = 4'hF;
        repeat (10) @(negedge clk);
        check("R2 rising edge ignored", {7'd0, irq}, 8'd0);

        // R5 higher priority arrives mid-service
        ant_right = 1'b0;
        pulse(4'b0001);
        wait_irq();
        pulse(4'b1000);
        repeat (5) @(negedge clk);
        check("R5 irq stays high", {7'd0, irq}, 8'd1);
        serve("R5 current source kept", 0, 1'b1);
        serve("R5 stored source served", 3, 1'b0);

        // R8 repeated edge on serviced source
        pulse(4'b0100);
        wait_irq();
        pulse(4'b0100);
        repeat (4) @(negedge clk);
        serve("R8 first service", 2, 1'b1);
        serve("R8 second service", 2, 1'b0);

        // R9 svc_done while idle ignored
        repeat (3) @(negedge clk);
        svc_done = 1'b1;
        @(negedge clk) svc_done = 1'b0;
        pulse(4'b0010);
        wait_irq();
        check("R9 irq after idle done", {7'd0, irq}, 8'd1);
        serve("R9 id after idle done", 1, 1'b0);

        id_rd = 1'b0;
        #1 check("R4 data zero unselected", rd_data, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule